// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the slave end of a two-wire serial management link. Each rising edge of its clock is one management clock edge, and on that edge the block samples the data input. From the incoming bit stream it recognises a frame start, collects a 12-bit header, and then carries out either a register read or a register write on an attached register bank through single-cycle strobes.

A read drives one zero turnaround bit and then 16 data bits onto the line, most significant bit first. The output enable marks when the line is driven. A write discards two turnaround bits, shifts in 16 data bits and then pulses a write strobe. Only one device is served, so the device-address field of the header is accepted whatever its value.

Top module: `mdio_slave`

## Requirements
- R1: After a synchronous reset, `mdio_oe`, `rd_stb` and `wr_stb` are 0, and the block waits in idle for a frame.
- R2: From idle, a sampled 0 arms the start state. Further 0s keep it waiting, and the first sampled 1 makes the next 12 sampled bits the header.
- R3: The header is taken MSB first as a 2-bit opcode, then a 5-bit device address, then a 5-bit register address. Opcode binary 10 is a read and binary 01 is a write. The register address appears on `reg_addr`.
- R4: The 5-bit device-address field has no effect: frames carrying any value in it are carried out.
- R5: For a read, `rd_stb` is high for exactly the one cycle that follows the edge sampling the last header bit. `reg_addr` is valid in that cycle and `rd_data` is captured at the end of it.
- R6: In that same cycle the block drives the turnaround bit as 0 with `mdio_oe` high.
- R7: For a read, the 16 data bits follow on the next 16 cycles, MSB first, on `mdio_o`. `mdio_oe` then drops and the block is idle.
- R8: For a write, the two bits after the header are ignored and the next 16 bits are shifted in MSB first. `wr_stb` is high for the one cycle after the edge sampling the 16th bit, with `reg_addr` and `wr_data` valid in that cycle.
- R9: A header whose opcode is 00 or 11 returns the block to idle with no strobe and no drive, and a following valid frame is served normally.
- R10: `mdio_oe` is high only during the read turnaround bit and the 16 read data bits, which is 17 consecutive cycles per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; each rising edge samples `mdio_i` |
| rst | input | 1 | Synchronous reset, active high |
| mdio_i | input | 1 | Serial data in from the line |
| mdio_o | output | 1 | Serial data out to the line |
| mdio_oe | output | 1 | High while the block drives the line |
| reg_addr | output | 5 | Register address for the bank |
| rd_stb | output | 1 | One-cycle read request |
| rd_data | input | 16 | Read data returned by the bank during `rd_stb` |
| wr_stb | output | 1 | One-cycle write request |
| wr_data | output | 16 | Write data, valid with `wr_stb` |

## Verification
Inputs change and outputs are sampled on the falling edge, so each sampled value is the state left by the rising edge just before it. A read is due on the sample taken right after the 14th frame bit (strobe, address and zero turnaround). Data bit 15 comes on the next sample and bit 0 sixteen samples later, and the enable is released on the sample after that. A write strobe is due on the sample right after the 32nd frame bit, and every other sample in the frame must show it low. The bench counts ticks per frame and compares each output only on its due sample. A bank modelled in the bench supplies read data, and frames with random device addresses, registers, data, opcodes and preamble lengths are checked against a reference copy of the register contents.

// File: rtl/mdio_slave.sv
module mdio_slave #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [AW-1:0] reg_addr,
  output logic          rd_stb,
  input  logic [DW-1:0] rd_data,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data
);
  localparam int HDR_BITS = 2 + 2 * AW;
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_HDR, S_TA_RD, S_TA_WR, S_READ, S_WRITE
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] acc;
  logic [AW-1:0] addr_q;
  logic          wr_stb_q;
  logic [DW-1:0] hdr_next;

  assign hdr_next = {acc[DW-2:0], mdio_i};
  assign reg_addr = addr_q;
  assign rd_stb   = (st == S_TA_RD);
  assign mdio_oe  = (st == S_TA_RD) || (st == S_READ);
  assign mdio_o   = (st == S_READ) ? acc[DW-1] : 1'b0;
  assign wr_stb   = wr_stb_q;
  assign wr_data  = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      acc      <= '0;
      addr_q   <= '0;
      wr_stb_q <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      case (st)
        S_IDLE:  if (!mdio_i) st <= S_START;
        S_START:
          if (mdio_i) begin
            st  <= S_HDR;
            cnt <= CW'(HDR_BITS - 1);
            acc <= '0;
          end
        S_HDR: begin
          acc <= hdr_next;
          if (cnt == '0) begin
            addr_q <= hdr_next[AW-1:0];
            case (hdr_next[HDR_BITS-1 -: 2])
              2'b10:   st <= S_TA_RD;
              2'b01: begin
                st  <= S_TA_WR;
                cnt <= CW'(1);
              end
              default: st <= S_IDLE;
            endcase
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_TA_RD: begin
          acc <= rd_data;
          cnt <= CW'(DW - 1);
          st  <= S_READ;
        end
        S_READ: begin
          acc <= {acc[DW-2:0], 1'b0};
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_TA_WR:
          if (cnt == '0) begin
            st  <= S_WRITE;
            cnt <= CW'(DW - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_WRITE: begin
          acc <= hdr_next;
          if (cnt == '0) begin
            wr_stb_q <= 1'b1;
            st       <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_rd_stb_single_R5: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);

  assert_wr_stb_single_R8: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_ta_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> (!mdio_o && rd_stb));

  assert_release_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> (st == S_IDLE));

  assert_drive_continues_R10: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (mdio_oe && !rd_stb));

  assert_no_drive_on_write_R10: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !mdio_oe);
endmodule

// File: tb/mdio_slave_tb.sv
module mdio_slave_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdio_i = 1'b1;
  logic        mdio_o, mdio_oe, rd_stb, wr_stb;
  logic [4:0]  reg_addr;
  logic [15:0] rd_data, wr_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] bank [32];
  logic [15:0] model [32];

  always #10 clk = ~clk;

  mdio_slave u_dut (
    .clk(clk), .rst(rst), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .reg_addr(reg_addr), .rd_stb(rd_stb), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_data(wr_data)
  );

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) bank[i] <= init_val(i);
    end else if (wr_stb) begin
      bank[reg_addr] <= wr_data;
    end
  end
  assign rd_data = bank[reg_addr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    mdio_i = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] data, input int pre, input int extra_zeros);
    logic [11:0] hdr;
    logic        quiet;
    logic [15:0] got;
    hdr = {op, phy, ra};
    quiet = 1'b1;
    for (int i = 0; i < pre; i++) begin
      tick(1'b1);
      quiet &= !mdio_oe && !rd_stb && !wr_stb;
    end
    for (int i = 0; i <= extra_zeros; i++) begin
      tick(1'b0);
      quiet &= !mdio_oe && !rd_stb && !wr_stb;
    end
    tick(1'b1);
    quiet &= !mdio_oe && !rd_stb && !wr_stb;
    for (int i = 11; i >= 0; i--) begin
      if (i == 0) begin
        tick(hdr[i]);
      end else begin
        tick(hdr[i]);
        quiet &= !mdio_oe && !rd_stb && !wr_stb;
      end
    end
    check("R2 quiet through start and header", {31'd0, quiet}, 32'd1);
    if (op == 2'b10) begin
      check("R5 read strobe after header", {31'd0, rd_stb}, 32'd1);
      check("R3/R4 read register address", {27'd0, reg_addr}, {27'd0, ra});
      check("R6 turnaround driven zero", {30'd0, mdio_oe, mdio_o}, 32'd2);
      got = '0;
      quiet = 1'b1;
      for (int i = 15; i >= 0; i--) begin
        tick(1'b1);
        got[i] = mdio_o;
        quiet &= mdio_oe && !rd_stb;
      end
      check("R7 read data MSB first", {16'd0, got}, {16'd0, model[ra]});
      check("R10 enable held for read bits", {31'd0, quiet}, 32'd1);
      tick(1'b1);
      check("R7 release after last bit", {31'd0, mdio_oe}, 32'd0);
    end else if (op == 2'b01) begin
      tick(1'b1);
      quiet &= !mdio_oe && !wr_stb;
      tick(1'b0);
      quiet &= !mdio_oe && !wr_stb;
      for (int i = 15; i >= 0; i--) begin
        if (i == 0) begin
          tick(data[i]);
        end else begin
          tick(data[i]);
          quiet &= !mdio_oe && !wr_stb;
        end
      end
      check("R10 no drive during write", {31'd0, quiet}, 32'd1);
      check("R8 write strobe after 16th bit", {31'd0, wr_stb}, 32'd1);
      check("R8 write address", {27'd0, reg_addr}, {27'd0, ra});
      check("R8 write data", {16'd0, wr_data}, {16'd0, data});
      model[ra] = data;
      tick(1'b1);
      check("R8 single write strobe", {31'd0, wr_stb}, 32'd0);
    end else begin
      quiet = !mdio_oe && !rd_stb && !wr_stb;
      for (int i = 0; i < 20; i++) begin
        tick(1'b1);
        quiet &= !mdio_oe && !rd_stb && !wr_stb;
      end
      check("R9 bad opcode ignored", {31'd0, quiet}, 32'd1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) model[i] = init_val(i);
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {29'd0, mdio_oe, rd_stb, wr_stb}, 32'd0);
    rst = 1'b0;
    tick(1'b1);
    check("R1 idle after reset", {29'd0, mdio_oe, rd_stb, wr_stb}, 32'd0);

    frame(2'b10, 5'd0, 5'd3, 16'h0, 8, 0);
    frame(2'b01, 5'd31, 5'd3, 16'h8001, 2, 0);
    frame(2'b10, 5'd17, 5'd3, 16'h0, 0, 0);
    frame(2'b01, 5'd9, 5'd31, 16'hFFFF, 4, 3);
    frame(2'b10, 5'd2, 5'd31, 16'h0, 1, 5);
    frame(2'b00, 5'd0, 5'd4, 16'h0, 3, 0);
    frame(2'b11, 5'd1, 5'd4, 16'h0, 3, 0);
    frame(2'b10, 5'd1, 5'd4, 16'h0, 3, 0);

    for (int n = 0; n < 300; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 9) < 1 ? $urandom_range(0, 1) * 3 : $urandom_range(1, 2));
      frame(op, 5'($urandom), 5'($urandom), 16'($urandom), $urandom_range(0, 6),
            $urandom_range(0, 2));
    end
    for (int i = 0; i < 32; i++) frame(2'b10, 5'($urandom), 5'(i), 16'h0, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule